// File: doc/BRIEF.md
# Stacked Die Pairing Engine

This engine decides which dies are bonded together into two-layer stacks. Each die has already been tested and classified. A die is described by four values:
- a signed spare-row balance: positive means spare rows are left over, negative means rows are missing;
- a signed spare-column balance, with the same sign convention;
- a count of isolated single-cell faults;
- a used flag held inside the engine.

Software first writes the die table through a load port while the engine is idle. It then pulses `start`.

Each pairing round has two steps:
- **Target pick.** The engine takes the unused die with the lowest combined balance (row plus column) as the target and marks it used at once.
- **Partner scan.** It walks the table again, looking for an unused partner. A partner must sit inside three windows at once: one on rows, one on columns, and one on the combined total. The combined window gives credit for single-cell faults, because such a fault can be mended by either a row or a column.

Of all acceptable partners, the one with the lowest combined balance wins. Every round ends with one report on the pair strobe. The report carries either the two die indices or a no-match flag with the target index. When no unused die remains, the engine raises `done`.

Both scans walk one table entry per clock, so a round costs about 2N+2 cycles and a full run costs O(N²) cycles.

Top module: `die_pair_engine`

## Requirements
- R1: A candidate passes the row window only if -RT <= RC <= RS. RT and RC are the row balances of the target and the candidate, and RS is the parameter SPARE_ROWS.
- R2: A candidate passes the column window only if -CT <= CC <= CS. CT and CC are the column balances, and CS is the parameter SPARE_COLS.
- R3: A candidate passes the combined window only if -RT-CT+ST+SC <= RC+CC <= RS+CS. ST and SC are the single-cell-fault counts of the target and the candidate. A partner must pass R1, R2 and R3 together.
- R4: The target of each round is the unused die with the smallest row+column balance. A tie goes to the lowest table index.
- R5: The target is marked used as soon as it is chosen. If no partner passes, the round is reported with `pairNoMatch`=1, `pairTarget` set to the target, and `pairMate`=0. That target never appears again.
- R6: Among the candidates that pass, the partner with the smallest row+column balance is chosen, with a tie going to the lowest index. It is marked used and reported with `pairNoMatch`=0.
- R7: Rounds repeat until every die is used. `done` then rises and stays high until the next accepted `start`.
- R8: An accepted `start` clears every used flag. A second run over an unchanged table therefore repeats the same report sequence.
- R9: After reset, `busy`, `done` and `pairValid` are all 0.
- R10: `pairValid` is a single-cycle strobe, one per round. Two consecutive cycles never both carry it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| loadEn | input | 1 | Write one table entry; ignored while busy |
| loadIdx | input | ID_W | Entry index to write |
| loadRow | input | ST_W | Signed spare-row balance |
| loadCol | input | ST_W | Signed spare-column balance |
| loadScf | input | SCF_W | Single-cell-fault count |
| start | input | 1 | Begin a pairing run when not busy |
| busy | output | 1 | Run in progress |
| done | output | 1 | All dies consumed; held until next start |
| pairValid | output | 1 | One-cycle report strobe per round |
| pairTarget | output | ID_W | Target die index |
| pairMate | output | ID_W | Partner die index (0 on no match) |
| pairNoMatch | output | 1 | Target left unpaired |

## Verification
A corrupted used flag or a stale best-so-far register shows up at the ports in the same round. The wrong die is reported, or a die is reported twice, or `done` arrives early. So the first report after the fault differs from the arithmetic model.

A window comparison with an off-by-one bound changes which partner is accepted. The bench recomputes all three inequalities from the loaded values for every reported pair. It also compares the whole report sequence, in order, against a model that scans the table the same way. Tables are swept across the full range of the small configuration, so boundary balances are hit directly.

// File: rtl/die_pair_pkg.sv
package die_pair_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TSCAN,
    ST_TPICK,
    ST_CSCAN,
    ST_EMIT,
    ST_DONE
  } pairState_t;

  typedef struct packed {
    logic clrUsed;
    logic clrScan;
    logic stepScan;
    logic mateMode;
    logic latchTgt;
    logic emit;
  } ctlStrobes_t;

endpackage

// File: rtl/die_pair_ctrl.sv
module die_pair_ctrl
  import die_pair_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        scanLast,
  input  logic        anyFree,
  output ctlStrobes_t stb,
  output logic        busy,
  output logic        done
);

  pairState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          stb.clrUsed = 1'b1;
          stb.clrScan = 1'b1;
          nextState   = ST_TSCAN;
        end
      end
      ST_TSCAN: begin
        stb.stepScan = 1'b1;
        if (scanLast) nextState = ST_TPICK;
      end
      ST_TPICK: begin
        if (!anyFree) begin
          nextState = ST_DONE;
        end else begin
          stb.latchTgt = 1'b1;
          stb.clrScan  = 1'b1;
          nextState    = ST_CSCAN;
        end
      end
      ST_CSCAN: begin
        stb.stepScan = 1'b1;
        stb.mateMode = 1'b1;
        if (scanLast) nextState = ST_EMIT;
      end
      ST_EMIT: begin
        stb.emit    = 1'b1;
        stb.clrScan = 1'b1;
        nextState   = ST_TSCAN;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE) && (state != ST_DONE);
  assign done = (state == ST_DONE);

  // R7: done is only reachable once the datapath has no free die left
  a_r7_done_exhausted: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !anyFree);

  // R9: leaving reset the engine is idle until start
  a_r9_idle_until_start: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy)) |-> $past(start));

endmodule

// File: rtl/die_pair_dpath.sv
module die_pair_dpath
  import die_pair_pkg::*;
#(
  parameter int NUM_DIES   = 8,
  parameter int ST_W       = 4,
  parameter int SCF_W      = 3,
  parameter int SPARE_ROWS = 1,
  parameter int SPARE_COLS = 2,
  localparam int ID_W      = (NUM_DIES > 1) ? $clog2(NUM_DIES) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctlStrobes_t            stb,
  input  logic                   loadWr,
  input  logic [ID_W-1:0]        loadIdx,
  input  logic signed [ST_W-1:0] loadRow,
  input  logic signed [ST_W-1:0] loadCol,
  input  logic [SCF_W-1:0]       loadScf,
  output logic                   scanLast,
  output logic                   anyFree,
  output logic                   pairValid,
  output logic [ID_W-1:0]        pairTarget,
  output logic [ID_W-1:0]        pairMate,
  output logic                   pairNoMatch
);

  localparam int CW  = ST_W + SCF_W + 3;
  localparam int KW  = ST_W + 1;
  localparam logic [ID_W-1:0] LAST_IDX = ID_W'(NUM_DIES - 1);
  localparam logic signed [CW-1:0] RS_C = CW'(SPARE_ROWS);
  localparam logic signed [CW-1:0] CS_C = CW'(SPARE_COLS);

  logic signed [ST_W-1:0] rowSt [NUM_DIES];
  logic signed [ST_W-1:0] colSt [NUM_DIES];
  logic [SCF_W-1:0]       scfCnt [NUM_DIES];
  logic [NUM_DIES-1:0]    usedVec;

  logic [ID_W-1:0]        scanIdx;
  logic [ID_W-1:0]        bestIdx;
  logic signed [KW-1:0]   bestKey;
  logic                   bestFound;

  logic signed [CW-1:0]   tRow, tCol, tScf;

  // table storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_DIES; i++) begin
        rowSt[i]  <= '0;
        colSt[i]  <= '0;
        scfCnt[i] <= '0;
      end
    end else if (loadWr) begin
      rowSt[loadIdx]  <= loadRow;
      colSt[loadIdx]  <= loadCol;
      scfCnt[loadIdx] <= loadScf;
    end
  end

  // per-entry used flags
  for (genvar g = 0; g < NUM_DIES; g++) begin : g_used
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        usedVec[g] <= 1'b0;
      else if (stb.clrUsed)
        usedVec[g] <= 1'b0;
      else if ((stb.latchTgt || (stb.emit && bestFound)) && bestIdx == ID_W'(g))
        usedVec[g] <= 1'b1;
    end
  end

  assign anyFree  = |(~usedVec);
  assign scanLast = (scanIdx == LAST_IDX);

  // candidate evaluation at the scan pointer
  logic signed [CW-1:0] cRow, cCol, cScf, cSum;
  logic signed [KW-1:0] cKey;
  logic rowOk, colOk, sumOk, candOk;

  always_comb begin
    cRow  = CW'(rowSt[scanIdx]);
    cCol  = CW'(colSt[scanIdx]);
    cScf  = CW'(scfCnt[scanIdx]);
    cSum  = cRow + cCol;
    cKey  = KW'(rowSt[scanIdx]) + KW'(colSt[scanIdx]);
    rowOk = (cRow >= -tRow) && (cRow <= RS_C);
    colOk = (cCol >= -tCol) && (cCol <= CS_C);
    sumOk = (cSum >= (tScf + cScf - tRow - tCol)) && (cSum <= RS_C + CS_C);
    candOk = !usedVec[scanIdx] && (!stb.mateMode || (rowOk && colOk && sumOk));
  end

  // scan pointer and best-so-far tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanIdx   <= '0;
      bestIdx   <= '0;
      bestKey   <= '0;
      bestFound <= 1'b0;
    end else if (stb.clrScan) begin
      scanIdx   <= '0;
      bestFound <= 1'b0;
    end else if (stb.stepScan) begin
      scanIdx <= scanIdx + ID_W'(1);
      if (candOk && (!bestFound || cKey < bestKey)) begin
        bestIdx   <= scanIdx;
        bestKey   <= cKey;
        bestFound <= 1'b1;
      end
    end
  end

  // target latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tRow       <= '0;
      tCol       <= '0;
      tScf       <= '0;
      pairTarget <= '0;
    end else if (stb.latchTgt) begin
      tRow       <= CW'(rowSt[bestIdx]);
      tCol       <= CW'(colSt[bestIdx]);
      tScf       <= CW'(scfCnt[bestIdx]);
      pairTarget <= bestIdx;
    end
  end

  // report
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pairValid   <= 1'b0;
      pairMate    <= '0;
      pairNoMatch <= 1'b0;
    end else begin
      pairValid <= stb.emit;
      if (stb.emit) begin
        pairMate    <= bestFound ? bestIdx : '0;
        pairNoMatch <= !bestFound;
      end
    end
  end

  // R10: report strobe lasts one cycle
  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    pairValid |=> !pairValid);

  // R5: a reported target is already consumed
  a_r5_target_used: assert property (@(posedge clk) disable iff (!rstN)
    pairValid |-> usedVec[pairTarget]);

  // R6: a reported partner is consumed and distinct from the target
  a_r6_mate_used: assert property (@(posedge clk) disable iff (!rstN)
    (pairValid && !pairNoMatch) |-> (usedVec[pairMate] && pairMate != pairTarget));

  // R1: reported partner row balance lies inside the row window
  a_r1_row_window: assert property (@(posedge clk) disable iff (!rstN)
    (pairValid && !pairNoMatch) |->
      (CW'(rowSt[pairMate]) >= -CW'(rowSt[pairTarget]) && CW'(rowSt[pairMate]) <= RS_C));

  // R4: a target is only latched when the target scan found a free die
  a_r4_target_found: assert property (@(posedge clk) disable iff (!rstN)
    stb.latchTgt |-> bestFound);

endmodule

// File: rtl/die_pair_engine.sv
module die_pair_engine
  import die_pair_pkg::*;
#(
  parameter int NUM_DIES   = 8,
  parameter int ST_W       = 4,
  parameter int SCF_W      = 3,
  parameter int SPARE_ROWS = 1,
  parameter int SPARE_COLS = 2,
  localparam int ID_W      = (NUM_DIES > 1) ? $clog2(NUM_DIES) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   loadEn,
  input  logic [ID_W-1:0]        loadIdx,
  input  logic signed [ST_W-1:0] loadRow,
  input  logic signed [ST_W-1:0] loadCol,
  input  logic [SCF_W-1:0]       loadScf,
  input  logic                   start,
  output logic                   busy,
  output logic                   done,
  output logic                   pairValid,
  output logic [ID_W-1:0]        pairTarget,
  output logic [ID_W-1:0]        pairMate,
  output logic                   pairNoMatch
);

  ctlStrobes_t stb;
  logic scanLast, anyFree;

  die_pair_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .scanLast (scanLast),
    .anyFree  (anyFree),
    .stb      (stb),
    .busy     (busy),
    .done     (done)
  );

  die_pair_dpath #(
    .NUM_DIES   (NUM_DIES),
    .ST_W       (ST_W),
    .SCF_W      (SCF_W),
    .SPARE_ROWS (SPARE_ROWS),
    .SPARE_COLS (SPARE_COLS)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .loadWr      (loadEn && !busy),
    .loadIdx     (loadIdx),
    .loadRow     (loadRow),
    .loadCol     (loadCol),
    .loadScf     (loadScf),
    .scanLast    (scanLast),
    .anyFree     (anyFree),
    .pairValid   (pairValid),
    .pairTarget  (pairTarget),
    .pairMate    (pairMate),
    .pairNoMatch (pairNoMatch)
  );

endmodule

// File: tb/die_pair_engine_tb_top.sv
module die_pair_engine_tb_top;

  localparam int N      = 6;
  localparam int STW    = 4;
  localparam int SCFW   = 3;
  localparam int RS     = 1;
  localparam int CS     = 2;
  localparam int IDW    = $clog2(N);
  localparam int CLK_PERIOD = 10;
  localparam int RUN_LIMIT  = 2000;

  logic clk = 0, rstN = 0;
  logic loadEn = 0, start = 0;
  logic [IDW-1:0] loadIdx = '0;
  logic signed [STW-1:0] loadRow = '0, loadCol = '0;
  logic [SCFW-1:0] loadScf = '0;
  logic busy, done, pairValid, pairNoMatch;
  logic [IDW-1:0] pairTarget, pairMate;

  always #(CLK_PERIOD/2) clk = ~clk;

  die_pair_engine #(.NUM_DIES(N), .ST_W(STW), .SCF_W(SCFW),
                    .SPARE_ROWS(RS), .SPARE_COLS(CS)) dut_i (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadIdx(loadIdx),
    .loadRow(loadRow), .loadCol(loadCol), .loadScf(loadScf), .start(start),
    .busy(busy), .done(done), .pairValid(pairValid), .pairTarget(pairTarget),
    .pairMate(pairMate), .pairNoMatch(pairNoMatch));

  int errors = 0, checks = 0;
  int tRow[N], tCol[N], tScf[N];
  int expT[N], expM[N], nExp;
  int actT[N + 4], actM[N + 4], actNm[N + 4], nAct;
  bit prevV = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit fits(input int t, input int c);
    int rSum;
    rSum = tRow[c] + tCol[c];
    return (tRow[c] >= -tRow[t]) && (tRow[c] <= RS) &&
           (tCol[c] >= -tCol[t]) && (tCol[c] <= CS) &&
           (rSum >= -tRow[t] - tCol[t] + tScf[t] + tScf[c]) && (rSum <= RS + CS);
  endfunction

  function automatic void model();
    bit used[N];
    int t, c;
    nExp = 0;
    for (int i = 0; i < N; i++) used[i] = 0;
    forever begin
      t = -1;
      for (int i = 0; i < N; i++)
        if (!used[i] && (t < 0 || tRow[i] + tCol[i] < tRow[t] + tCol[t])) t = i;
      if (t < 0) break;
      used[t] = 1;
      c = -1;
      for (int i = 0; i < N; i++)
        if (!used[i] && fits(t, i) && (c < 0 || tRow[i] + tCol[i] < tRow[c] + tCol[c])) c = i;
      if (c >= 0) used[c] = 1;
      expT[nExp] = t;
      expM[nExp] = c;
      nExp++;
    end
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      if (pairValid) chk(!prevV, "R10", 1, 0);
      if (pairValid && nAct < N + 4) begin
        actT[nAct]  = pairTarget;
        actM[nAct]  = pairMate;
        actNm[nAct] = pairNoMatch;
        nAct++;
      end
      prevV = pairValid;
    end
  end

  task automatic loadTable();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      loadEn = 1; loadIdx = IDW'(i);
      loadRow = STW'(tRow[i]); loadCol = STW'(tCol[i]); loadScf = SCFW'(tScf[i]);
    end
    @(negedge clk);
    loadEn = 0;
  endtask

  task automatic runAndCompare(input bit reload);
    int cyc;
    if (reload) loadTable();
    model();
    @(negedge clk);
    nAct = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy && !done, "R7", done, 0);
    cyc = 0;
    while (!done && cyc < RUN_LIMIT) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc < RUN_LIMIT, "R7", cyc, RUN_LIMIT);
    @(negedge clk);
    chk(done && !busy, "R7", done, 1);
    chk(nAct == nExp, "R7", nAct, nExp);
    for (int k = 0; k < nExp && k < nAct; k++) begin
      chk(actT[k] == expT[k], "R4", actT[k], expT[k]);
      if (expM[k] < 0) begin
        chk(actNm[k] == 1 && actM[k] == 0, "R5", actM[k], 0);
      end else begin
        chk(actNm[k] == 0 && actM[k] == expM[k], "R6", actM[k], expM[k]);
        chk(tRow[actM[k]] >= -tRow[actT[k]] && tRow[actM[k]] <= RS, "R1", tRow[actM[k]], RS);
        chk(tCol[actM[k]] >= -tCol[actT[k]] && tCol[actM[k]] <= CS, "R2", tCol[actM[k]], CS);
        chk(fits(actT[k], actM[k]), "R3", 0, 1);
      end
    end
  endtask

  initial begin
    int wd;
    wd = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !pairValid, "R9", {busy, done, pairValid}, 0);
    rstN = 1;
    @(negedge clk);
    chk(!busy && !done && !pairValid, "R9", {busy, done, pairValid}, 0);

    // all dies with full spares: pairs in index order
    for (int i = 0; i < N; i++) begin tRow[i] = RS; tCol[i] = CS; tScf[i] = 0; end
    runAndCompare(1);
    // all deficient dies: every target left unpaired (R5)
    for (int i = 0; i < N; i++) begin tRow[i] = -1; tCol[i] = -2; tScf[i] = 0; end
    runAndCompare(1);
    // single-cell credit decides the partner (R3)
    tRow[0] = -1; tCol[0] = 0; tScf[0] = 1;
    tRow[1] = 1;  tCol[1] = 1; tScf[1] = 1;
    tRow[2] = 1;  tCol[2] = 1; tScf[2] = 0;
    tRow[3] = 0;  tCol[3] = 2; tScf[3] = 0;
    tRow[4] = 1;  tCol[4] = 2; tScf[4] = 2;
    tRow[5] = 0;  tCol[5] = 0; tScf[5] = 0;
    runAndCompare(1);
    // R8: restart without reload repeats the sequence
    runAndCompare(0);

    // sweep of pseudo-random tables across the legal state range
    for (int r = 0; r < 60; r++) begin
      for (int i = 0; i < N; i++) begin
        tRow[i] = $urandom_range(2, 0) - 1;
        tCol[i] = $urandom_range(4, 0) - 2;
        tScf[i] = $urandom_range(2, 0);
      end
      runAndCompare(1);
      if (r % 10 == 0) runAndCompare(0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule